// File: doc/BRIEF.md
# Staged System Reset Sequencer

This block turns one external, asynchronous, active-high reset request into three synchronous, active-high reset outputs that release in a fixed order. The bus fabric (arbiters and bridges) leaves reset first. The peripheral group leaves reset a fixed number of clocks later. The processor group leaves reset the same number of clocks after the peripherals. The default gap is 16 clocks. A completion flag shows that every group has been released.

The external request asserts all outputs at once, with no clock needed. Its deassertion passes through a two-stage synchronizer before the block acts on it. The sequence then waits for a ready input, such as a clock-generator lock, before releasing anything. After the sequence has started, the ready input has no effect. A new external request at any point, during the sequence or after it, asserts every output again and restarts the sequence from the beginning with full timing.

Top module: `staged_reset_seq`

## Requirements
- R1: While `ext_rst_in` is high, `rst_bus_o`, `rst_periph_o` and `rst_cpu_o` are 1 and `seq_done_o` is 0. These values appear as soon as `ext_rst_in` rises, before the next clock edge.
- R2: After `ext_rst_in` falls between two clock edges, the earliest release of `rst_bus_o` is at the third rising edge that follows. This is the delay of the two-stage synchronizer.
- R3: `rst_bus_o` is released only at a rising edge where `lock_ok_i` is 1 and the synchronized reset has cleared. While `lock_ok_i` stays 0, all three resets stay at 1.
- R4: `rst_periph_o` falls exactly GAP_CYCLES (16) rising edges after `rst_bus_o` falls.
- R5: `rst_cpu_o` falls exactly GAP_CYCLES (16) rising edges after `rst_periph_o` falls.
- R6: `seq_done_o` rises at the same edge at which `rst_cpu_o` falls, and it is 0 whenever any reset output is 1.
- R7: After `rst_bus_o` has been released, changes on `lock_ok_i` do not change the timing of the remaining releases.
- R8: Raising `ext_rst_in` in the middle of the sequence, or after it has completed, asserts all outputs again. The following release then repeats the full timing of R2 to R6.
- R9: A released reset output stays at 0 until `ext_rst_in` rises again.
- R10: The release order always holds: `rst_periph_o` is never 0 while `rst_bus_o` is 1, and `rst_cpu_o` is never 0 while `rst_periph_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all reset outputs |
| ext_rst_in | input | 1 | External asynchronous reset request, active high |
| lock_ok_i | input | 1 | Ready qualifier that gates the start of the release sequence |
| rst_bus_o | output | 1 | Bus fabric reset, active high, released first |
| rst_periph_o | output | 1 | Peripheral reset, active high, released second |
| rst_cpu_o | output | 1 | Processor reset, active high, released last |
| seq_done_o | output | 1 | High once every group has been released |

## Verification
The hardest case to reach is a new reset request that lands inside a release gap, after the bus group has already been released. It must wipe out partial progress, and the next run must still show exact 16-clock gaps. The stimulus reaches it by waiting until the bench has seen `rst_bus_o` fall, counting a few clocks into the first gap, and then raising `ext_rst_in` at a falling edge. In the restarted run, `lock_ok_i` is dropped partway through a gap. This shows that the ready input is ignored once the sequence has begun.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_GAP  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_in,
  output logic sync_rst_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign sync_rst_o = chain_q[STAGES-1];

  // R2: the synchronized reset never clears while the raw request is active
  assert_sync_follows_R2: assert property (@(posedge clk) disable iff (arst_in)
    $past(arst_in) |-> sync_rst_o);

endmodule

// File: rtl/rstseq_gap_timer.sv
module rstseq_gap_timer #(
  parameter int GAP = 16
) (
  input  logic clk,
  input  logic arst_in,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int CW = $clog2(GAP + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (run_i)    cnt_q <= cnt_q + 1'b1;
  end

  // R4: the gap counter never runs beyond its terminal value
  assert_gap_bound_R4: assert property (@(posedge clk) disable iff (arst_in)
    cnt_q <= LAST);

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int GAP        = 16
) (
  input  logic                  clk,
  input  logic                  arst_in,
  input  logic                  sync_rst_i,
  input  logic                  lock_ok_i,
  output logic [NUM_GROUPS-1:0] grp_rst_o,
  output logic                  done_o
);

  localparam int IW = $clog2(NUM_GROUPS + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_GROUPS - 1);

  seq_state_e            state_q;
  logic [IW-1:0]         idx_q;
  logic                  start;
  logic                  expire;
  logic [NUM_GROUPS-1:0] rel_pulse;
  logic [NUM_GROUPS-1:0] grp_q;
  logic                  done_q;

  assign start = (state_q == SEQ_HOLD) && !sync_rst_i && lock_ok_i;

  rstseq_gap_timer #(.GAP(GAP)) u_timer (
    .clk      (clk),
    .arst_in  (arst_in),
    .clear_i  (start),
    .run_i    (state_q == SEQ_GAP),
    .expire_o (expire)
  );

  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in) begin
      state_q <= SEQ_HOLD;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SEQ_HOLD: if (start) begin
          idx_q   <= IW'(1);
          state_q <= (NUM_GROUPS > 1) ? SEQ_GAP : SEQ_DONE;
        end
        SEQ_GAP: if (expire) begin
          if (idx_q == LAST_IDX) state_q <= SEQ_DONE;
          else                   idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= SEQ_DONE;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      if (g == 0) begin : g_first
        assign rel_pulse[g] = start;
      end else begin : g_later
        assign rel_pulse[g] = expire && (idx_q == IW'(g));
        // R10: a later group is only released after the group before it
        assert_release_order_R10: assert property (@(posedge clk) disable iff (arst_in)
          !grp_rst_o[g] |-> !grp_rst_o[g-1]);
      end

      always_ff @(posedge clk or posedge arst_in) begin
        if (arst_in)           grp_q[g] <= 1'b1;
        else if (rel_pulse[g]) grp_q[g] <= 1'b0;
      end

      // R9: once released, a group stays released
      assert_stay_released_R9: assert property (@(posedge clk) disable iff (arst_in)
        !grp_rst_o[g] |=> !grp_rst_o[g]);
    end
  endgenerate

  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in)                       done_q <= 1'b0;
    else if (rel_pulse[NUM_GROUPS-1])  done_q <= 1'b1;
  end

  assign grp_rst_o = grp_q;
  assign done_o    = done_q;

  // R3: the first release only happens when ready was seen at that edge
  assert_lock_gate_R3: assert property (@(posedge clk) disable iff (arst_in)
    $fell(grp_rst_o[0]) |-> $past(lock_ok_i));

  // R6: completion flag never shows while the last group is held
  assert_done_low_R6: assert property (@(posedge clk) disable iff (arst_in)
    done_o |-> !grp_rst_o[NUM_GROUPS-1]);

  // R6: completion flag rises together with the last release
  assert_done_with_last_R6: assert property (@(posedge clk) disable iff (arst_in)
    $fell(grp_rst_o[NUM_GROUPS-1]) |-> $rose(done_o));

endmodule

// File: rtl/staged_reset_seq.sv
module staged_reset_seq #(
  parameter int GAP_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic ext_rst_in,
  input  logic lock_ok_i,
  output logic rst_bus_o,
  output logic rst_periph_o,
  output logic rst_cpu_o,
  output logic seq_done_o
);

  localparam int NGRP = 3;
  localparam int MW   = $clog2(GAP_CYCLES + 2);
  localparam logic [MW-1:0] MSAT = MW'(GAP_CYCLES + 1);

  logic            sync_rst;
  logic [NGRP-1:0] grp_rst;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .arst_in    (ext_rst_in),
    .sync_rst_o (sync_rst)
  );

  rstseq_ctrl #(.NUM_GROUPS(NGRP), .GAP(GAP_CYCLES)) u_ctrl (
    .clk        (clk),
    .arst_in    (ext_rst_in),
    .sync_rst_i (sync_rst),
    .lock_ok_i  (lock_ok_i),
    .grp_rst_o  (grp_rst),
    .done_o     (seq_done_o)
  );

  assign rst_bus_o    = grp_rst[0];
  assign rst_periph_o = grp_rst[1];
  assign rst_cpu_o    = grp_rst[2];

  // Checker counters: how long each earlier group has been out of reset
  logic [MW-1:0] chk_bus_low, chk_per_low;

  always_ff @(posedge clk or posedge ext_rst_in) begin
    if (ext_rst_in)                chk_bus_low <= '0;
    else if (rst_bus_o)            chk_bus_low <= '0;
    else if (chk_bus_low != MSAT)  chk_bus_low <= chk_bus_low + 1'b1;
  end

  always_ff @(posedge clk or posedge ext_rst_in) begin
    if (ext_rst_in)                chk_per_low <= '0;
    else if (rst_periph_o)         chk_per_low <= '0;
    else if (chk_per_low != MSAT)  chk_per_low <= chk_per_low + 1'b1;
  end

  // R4: peripheral release lands exactly one gap after the bus release
  assert_periph_gap_R4: assert property (@(posedge clk) disable iff (ext_rst_in)
    $fell(rst_periph_o) |-> chk_bus_low == MW'(GAP_CYCLES));

  // R5: processor release lands exactly one gap after the peripheral release
  assert_cpu_gap_R5: assert property (@(posedge clk) disable iff (ext_rst_in)
    $fell(rst_cpu_o) |-> chk_per_low == MW'(GAP_CYCLES));

  // R1: right after a request ends, every output is still asserted
  assert_held_after_req_R1: assert property (@(posedge clk) disable iff (ext_rst_in)
    $past(ext_rst_in) |-> (rst_bus_o && rst_periph_o && rst_cpu_o && !seq_done_o));

  // R2: the bus release needs two clean synchronizer edges first
  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (ext_rst_in)
    $fell(rst_bus_o) |-> (!$past(ext_rst_in) && !$past(ext_rst_in, 2)));

endmodule

// File: tb/test_staged_reset_seq.sv
module test_staged_reset_seq;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 16;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0;
  logic ext_rst = 1'b0;
  logic lock = 1'b0;
  logic rst_bus, rst_per, rst_cpu, done;

  staged_reset_seq #(.GAP_CYCLES(GAP), .SYNC_STAGES(2)) i_staged_reset_seq (
    .clk          (clk),
    .ext_rst_in   (ext_rst),
    .lock_ok_i    (lock),
    .rst_bus_o    (rst_bus),
    .rst_periph_o (rst_per),
    .rst_cpu_o    (rst_cpu),
    .seq_done_o   (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  // Behavioural reference: phase 0 waiting, 1 first gap, 2 second gap, 3 complete
  bit m_bus = 1, m_per = 1, m_cpu = 1, m_done = 0;
  int m_sync = 0, m_phase = 0, m_t = 0;

  always @(posedge clk or posedge ext_rst) begin
    if (ext_rst) begin
      m_bus = 1; m_per = 1; m_cpu = 1; m_done = 0;
      m_sync = 0; m_phase = 0; m_t = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else if (m_phase == 0) begin
      if (lock) begin m_bus = 0; m_phase = 1; m_t = 0; end
    end else if (m_phase == 1) begin
      if (m_t == GAP-1) begin m_per = 0; m_phase = 2; m_t = 0; end
      else m_t++;
    end else if (m_phase == 2) begin
      if (m_t == GAP-1) begin m_cpu = 0; m_done = 1; m_phase = 3; end
      else m_t++;
    end
  end

  int t_bus, t_per, t_cpu, t_done;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic clear_marks();
    t_bus = -1; t_per = -1; t_cpu = -1; t_done = -1;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    chk(rst_bus == m_bus, "R3", "model rst_bus", rst_bus, m_bus);
    chk(rst_per == m_per, "R4", "model rst_periph", rst_per, m_per);
    chk(rst_cpu == m_cpu, "R5", "model rst_cpu", rst_cpu, m_cpu);
    chk(done == m_done, "R6", "model done", done, m_done);
    if (!rst_bus && t_bus < 0) t_bus = cyc;
    if (!rst_per && t_per < 0) t_per = cyc;
    if (!rst_cpu && t_cpu < 0) t_cpu = cyc;
    if (done && t_done < 0) t_done = cyc;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic raise_req();
    ext_rst = 1'b1;
    #1;
    chk(rst_bus && rst_per && rst_cpu && !done, "R1", "async assert",
        {rst_bus, rst_per, rst_cpu, done}, 4'b1110);
  endtask

  task automatic check_gaps(input string req);
    chk(t_per - t_bus == GAP, req, "bus->periph gap", t_per - t_bus, GAP);
    chk(t_cpu - t_per == GAP, req, "periph->cpu gap", t_cpu - t_per, GAP);
    chk(t_done == t_cpu, "R6", "done with cpu", t_done, t_cpu);
  endtask

  initial begin
    int c0;
    clear_marks();
    #1;
    raise_req();
    steps(3);
    chk(rst_bus && rst_per && rst_cpu && !done, "R1", "held during request",
        {rst_bus, rst_per, rst_cpu, done}, 4'b1110);

    // Lock low: nothing may release
    ext_rst = 1'b0;
    steps(12);
    chk(rst_bus == 1'b1, "R3", "bus held without lock", rst_bus, 1);
    c0 = cyc;
    lock = 1'b1;
    steps(40);
    chk(t_bus == c0 + 1, "R3", "bus release after lock", t_bus, c0 + 1);
    check_gaps("R4");
    chk(t_cpu - t_bus == 2*GAP, "R5", "bus->cpu span", t_cpu - t_bus, 2*GAP);
    chk(!rst_bus && !rst_per && !rst_cpu && done, "R9", "stays released",
        {rst_bus, rst_per, rst_cpu, done}, 4'b0001);

    // Request after completion, lock already high: synchronizer latency
    raise_req();
    steps(2);
    clear_marks();
    ext_rst = 1'b0;
    c0 = cyc;
    steps(2);
    chk(rst_bus == 1'b1, "R2", "bus held through sync", rst_bus, 1);
    step();
    chk(t_bus == c0 + 3, "R2", "bus release edge", t_bus, c0 + 3);

    // Mid-gap request restarts everything
    steps(5);
    raise_req();
    chk(rst_bus == 1'b1, "R8", "bus reasserted mid-gap", rst_bus, 1);
    steps(2);
    clear_marks();
    ext_rst = 1'b0;
    c0 = cyc;
    steps(7);
    chk(t_bus == c0 + 3, "R8", "restart bus release", t_bus, c0 + 3);
    lock = 1'b0;     // ignored from here on
    steps(10);
    lock = 1'b1;
    steps(3);
    lock = 1'b0;
    steps(20);
    check_gaps("R7");
    chk(done == 1'b1, "R7", "done despite lock drop", done, 1);
    chk(rst_per == 1'b0 && rst_bus == 1'b0, "R10", "order after completion",
        {rst_bus, rst_per}, 0);

    // Full restart after completion with lock low at first
    raise_req();
    steps(3);
    clear_marks();
    ext_rst = 1'b0;
    steps(5);
    chk(rst_bus == 1'b1, "R3", "bus held, lock low again", rst_bus, 1);
    c0 = cyc;
    lock = 1'b1;
    steps(40);
    chk(t_bus == c0 + 1, "R8", "rerun bus release", t_bus, c0 + 1);
    check_gaps("R8");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (R1..): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule